// File: doc/BRIEF.md
# Rotary Encoder Delay Setter

This block turns the detents of a two-phase rotary encoder into changes of an 8-bit delay setting. That setting is the high byte of the target delay in memory entries, so one detent changes the target by 256 entries. Both encoder phases pass through a synchronizer. The block then samples them only once per window of frame ticks. A tick arrives once per audio frame, and the window is 64 frames by default. Sampling this slowly is the only debouncing the block performs.

Each sample reads phase A together with a stored "A was low" flag. A new falling edge on A counts as one detent. The level of phase B at that sample sets the direction. The setting wraps freely in both directions. A one-clock step pulse marks every change so that downstream logic can react.

Top module: `enc_delay_setter`

## Requirements
- R1: After reset `delay_hi` is 0, `step_pulse` is 0 and the "A low" flag is clear, and the first frame tick after reset is a sampling tick.
- R2: Only frame ticks number 0, 64, 128, ... after reset sample the encoder (the window length is PRESCALE). Every other tick, and every clock without a tick, leaves `delay_hi` unchanged and `step_pulse` low, whatever the encoder does.
- R3: A sample that sees A high (1) clears the flag and leaves `delay_hi` unchanged.
- R4: A sample that sees A low (0) while the flag is set leaves `delay_hi` unchanged.
- R5: A sample that sees A low while the flag is clear sets the flag. If B is low (0), `delay_hi` increases by one.
- R6: Under the same condition with B high (1), `delay_hi` decreases by one.
- R7: `delay_hi` wraps: 255 plus one gives 0, and 0 minus one gives 255.
- R8: `step_pulse` is high for exactly the one clock after the edge at which `delay_hi` changes, and at no other time.
- R9: The encoder inputs pass through two flip-flop stages. A level applied at the clock edge that carries a sampling tick is not seen by that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-clock strobe, once per frame |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| delay_hi | output | 8 | Desired delay high byte |
| step_pulse | output | 1 | One-clock pulse on every change of `delay_hi` |

## Verification
The bench tracks the tick count itself and checks every non-sampling tick for silence, including while A toggles between samples. A design that counted windows wrongly would step at the wrong tick or step twice. Holding A low over several samples exposes a design that skipped the flag, because it would keep stepping. Wrapping in both directions exposes saturation. The bench also changes A on the same edge as a sampling tick, which exposes a synchronizer that is missing or one stage short.

// File: rtl/encd_pkg.sv
package encd_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/encd_sync.sv
module encd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/encd_prescaler.sv
module encd_prescaler #(
  parameter int PRESCALE = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic strobe
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign strobe = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (strobe) cnt_q <= RELOAD;
    else if (tick)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/encd_detent.sv
module encd_detent
  import encd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      strobe,
  input  logic      a_lvl,
  input  logic      b_lvl,
  output step_dir_e dir
);
  logic a_low_q;

  always_comb begin
    dir = STEP_NONE;
    if (strobe && !a_lvl && !a_low_q)
      dir = b_lvl ? STEP_DOWN : STEP_UP;
  end

  always_ff @(posedge clk) begin
    if (rst)
      a_low_q <= 1'b0;
    else if (strobe)
      a_low_q <= !a_lvl;
  end
endmodule

// File: rtl/encd_accum.sv
module encd_accum
  import encd_pkg::*;
#(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  step_dir_e          dir,
  output logic [DELAY_W-1:0] value,
  output logic               pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      unique case (dir)
        STEP_UP: begin
          value <= value + 1'b1;
          pulse <= 1'b1;
        end
        STEP_DOWN: begin
          value <= value - 1'b1;
          pulse <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/enc_delay_setter.sv
module enc_delay_setter
  import encd_pkg::*;
#(
  parameter int PRESCALE    = 64,
  parameter int DELAY_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_tick,
  input  logic               enc_a,
  input  logic               enc_b,
  output logic [DELAY_W-1:0] delay_hi,
  output logic               step_pulse
);
  logic [1:0] enc_sync;
  logic       a_sync;
  logic       b_sync;
  logic       sample_stb;
  step_dir_e  step_dir;

  encd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({enc_b, enc_a}), .q(enc_sync)
  );

  assign a_sync = enc_sync[0];
  assign b_sync = enc_sync[1];

  encd_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .tick(frame_tick), .strobe(sample_stb)
  );

  encd_detent u_det (
    .clk(clk), .rst(rst), .strobe(sample_stb),
    .a_lvl(a_sync), .b_lvl(b_sync), .dir(step_dir)
  );

  encd_accum #(.DELAY_W(DELAY_W)) u_acc (
    .clk(clk), .rst(rst), .dir(step_dir),
    .value(delay_hi), .pulse(step_pulse)
  );
endmodule

// File: rtl/enc_delay_setter_chk.sv
module enc_delay_setter_chk #(
  parameter int DELAY_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_tick,
  input logic               b_sampled,
  input logic [DELAY_W-1:0] delay_hi,
  input logic               step_pulse
);
  // R8
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (delay_hi != $past(delay_hi)) |-> step_pulse);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse);

  // R2
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_tick) |-> !step_pulse);

  // R7
  step_unit_chk: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> ((delay_hi == DELAY_W'($past(delay_hi) + 1'b1)) ||
                    (delay_hi == DELAY_W'($past(delay_hi) - 1'b1))));

  // R5
  step_dir_chk: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> ((delay_hi == DELAY_W'($past(delay_hi) + 1'b1)) == !$past(b_sampled)));
endmodule

bind enc_delay_setter enc_delay_setter_chk #(.DELAY_W(DELAY_W)) u_chk (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .b_sampled(b_sync),
  .delay_hi(delay_hi), .step_pulse(step_pulse)
);

// File: tb/enc_delay_setter_tb.sv
module enc_delay_setter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic       enc_a = 1'b1;
  logic       enc_b = 1'b0;
  logic [7:0] delay_hi;
  logic       step_pulse;

  int checks = 0;
  int failures = 0;
  int tcount = 0;
  logic [7:0] m_delay = 8'd0;
  logic       m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_delay_setter u_dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .enc_a(enc_a), .enc_b(enc_b),
    .delay_hi(delay_hi), .step_pulse(step_pulse)
  );

  task automatic check(input string req, input logic [7:0] exp_d, input logic exp_p);
    checks++;
    if (delay_hi !== exp_d || step_pulse !== exp_p) begin
      failures++;
      $display("FAIL %s: delay_hi=%0d step_pulse=%0b expected delay_hi=%0d step_pulse=%0b",
               req, delay_hi, step_pulse, exp_d, exp_p);
    end
  endtask

  // one tick, outputs checked half a clock after the capturing edge
  task automatic tick_once(input string req, input logic [7:0] exp_d, input logic exp_p);
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    check(req, exp_d, exp_p);
    tcount++;
  endtask

  task automatic skip_to_sample(input string req);
    while (tcount % WINDOW != 0) tick_once(req, m_delay, 1'b0);
  endtask

  task automatic settle(input logic a, input logic b);
    @(negedge clk);
    enc_a = a;
    enc_b = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic sample(input string req, input logic a, input logic b);
    logic p;
    settle(a, b);
    skip_to_sample("R2");
    p = 1'b0;
    if (a) m_flag = 1'b0;
    else if (!m_flag) begin
      m_flag = 1'b1;
      p = 1'b1;
      m_delay = b ? m_delay - 8'd1 : m_delay + 8'd1;
    end
    tick_once(req, m_delay, p);
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 8'd0, 1'b0);
  endtask

  task automatic test_toggle_between;
    settle(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      enc_a = ~enc_a;
      tick_once("R2", m_delay, 1'b0);
    end
    @(negedge clk) enc_a = 1'b1;
  endtask

  task automatic test_no_tick;
    settle(1'b0, 1'b0);
    repeat (50) @(negedge clk) enc_a = ~enc_a;
    check("R2", m_delay, 1'b0);
    settle(1'b1, 1'b0);
  endtask

  task automatic test_sync_latency;
    sample("R3", 1'b1, 1'b0);
    while ((tcount + 1) % WINDOW != 0) tick_once("R2", m_delay, 1'b0);
    tick_once("R2", m_delay, 1'b0);
    @(negedge clk);
    enc_a = 1'b0;
    frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    check("R9", m_delay, 1'b0);
    tcount++;
    sample("R9", 1'b0, 1'b0);
  endtask

  initial begin
    test_reset();
    sample("R1", 1'b0, 1'b0);
    sample("R4", 1'b0, 1'b0);
    sample("R4", 1'b0, 1'b1);
    sample("R3", 1'b1, 1'b1);
    sample("R6", 1'b0, 1'b1);
    sample("R3", 1'b1, 1'b0);
    sample("R7", 1'b0, 1'b1);
    sample("R3", 1'b1, 1'b0);
    sample("R5", 1'b0, 1'b0);
    sample("R3", 1'b1, 1'b0);
    sample("R7", 1'b0, 1'b0);
    test_toggle_between();
    test_no_tick();
    test_sync_latency();
    sample("R8", 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule